// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Each partial-product bit is one AND of a multiplicand bit and a multiplier bit. The multiplier is built as a regular grid. Row 0 holds the first partial-product row. Each later row of full adders adds one more partial-product row into a running sum. Every full adder passes its carry-out down to the row below, never sideways to its neighbour, so no carry ripples inside a row. Below the last row, an N-bit ripple adder merges the remaining sum and carry vectors into the upper half of the product. The lower half is made of the least significant sum bit of each row, which becomes final as soon as that row is done.

A bit mask parameter, `STAGE_MASK`, sets where registers go. Bit j (for j from 0 to N-1) places a register after row j. Bit N places a register after the final adder. Where a boundary is registered, three things cross it together: the running sum and carry vectors, the product bits finished so far, and both operands for the rows further down. A valid flag travels in step with this data. The latency in cycles is the number of set bits in the mask. A mask of all zeros gives a purely combinational multiplier.

The stream interface has no back-pressure. A new operand pair is taken on every cycle that `in_valid` is high, with no stall and no ready signal in either direction. The consumer must take each result in the cycle in which `out_valid` is high.

Top module: `csa_array_mul`

## Requirements
- R1: When `out_valid` is high, `product` equals the unsigned product of the `a_in` and `b_in` that were presented with `in_valid` high exactly L cycles earlier, where L is the number of set bits in `STAGE_MASK`.
- R2: `out_valid` is high in a cycle if and only if `in_valid` was high exactly L cycles earlier. An isolated input pulse gives exactly one output pulse.
- R3: An operand pair is accepted on every consecutive cycle, with no stall. Back-to-back pairs each come out one per cycle, in order, with correct products.
- R4: While `rst_n` is low and L is greater than 0, `out_valid` is 0. When `STAGE_MASK` bit N is set, `product` is also 0 during reset.
- R5: Operand values presented with `in_valid` low are ignored. They never raise `out_valid`.
- R6: With `STAGE_MASK` all zeros, the block is combinational: `out_valid` follows `in_valid` and `product` equals `a_in*b_in` in the same cycle.
- R7: The boundary operands give the exact results: a zero operand gives a product of 0, and 2^N-1 times 2^N-1 gives 2^(2N) - 2^(N+1) + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | N | Multiplicand, unsigned |
| b_in | input | N | Multiplier, unsigned |
| in_valid | input | 1 | Operand pair is present this cycle |
| product | output | 2N | Unsigned product |
| out_valid | output | 1 | Product is present this cycle |

## Verification
Several kinds of internal fault show up at the ports as a wrong product. These include a carry sent sideways instead of down, a partial product taken from the wrong multiplier bit, and an operand copy that falls out of step with its partial sums. Such a fault appears exactly L cycles after the offending pair enters, and usually only for some operand patterns. This is why every pair of a small configuration is streamed through back to back. A misplaced or missing valid register shows up as an out_valid pulse one cycle early or late, or as a lost pulse. An isolated pulse exposes this at once, and gapped traffic exposes it as well.

// File: rtl/csa_mul_pkg.sv
`timescale 1ns/1ps
package csa_mul_pkg;

  // Sum output of a full adder.
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // Carry output of a full adder (majority of the three inputs).
  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction

  // Number of set bits among the lowest n bits of a stage mask.
  function automatic int unsigned count_ones(input logic [63:0] m, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) begin
      if (m[i]) c = c + 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/csa_fa_row.sv
`timescale 1ns/1ps
// One row of carry-save full adders: three N-bit vectors in, sum and carry out.
module csa_fa_row #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] pp,
  input  logic [N-1:0] s_in,
  input  logic [N-1:0] c_in,
  output logic [N-1:0] s_out,
  output logic [N-1:0] c_out
);
  import csa_mul_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign s_out[i] = fa_sum(pp[i], s_in[i], c_in[i]);
    assign c_out[i] = fa_carry(pp[i], s_in[i], c_in[i]);
  end
endmodule

// File: rtl/csa_ripple_add.sv
`timescale 1ns/1ps
// N-bit ripple carry adder; the final carry-out is not formed.
module csa_ripple_add #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] sum
);
  import csa_mul_pkg::*;

  logic [N-1:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum[i] = fa_sum(x[i], y[i], cy[i]);
    if (i < N - 1) begin : g_cy
      assign cy[i+1] = fa_carry(x[i], y[i], cy[i]);
    end
  end
endmodule

// File: rtl/csa_stage_reg.sv
`timescale 1ns/1ps
// Optional pipeline boundary. When REGISTER is 0 the data passes straight
// through and the unloaded flops are removed by synthesis.
module csa_stage_reg #(
  parameter int unsigned W        = 8,
  parameter bit          REGISTER = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= d;
  end

  assign q = REGISTER ? q_r : d;
endmodule

// File: rtl/csa_array_mul.sv
`timescale 1ns/1ps
// Unsigned N x N carry-save array multiplier with per-row pipeline boundaries.
module csa_array_mul #(
  parameter int unsigned N          = 8,
  parameter logic [N:0]  STAGE_MASK = 9'b1_0010_0100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  input  logic           in_valid,
  output logic [2*N-1:0] product,
  output logic           out_valid
);
  localparam int unsigned PW = 2 * N;
  localparam int unsigned RW = 1 + 5 * N;  // valid, a, b, sum, carry, low bits

  // Values entering each boundary (_d) and leaving it (_q), per row.
  logic         v_d  [N];
  logic [N-1:0] a_d  [N];
  logic [N-1:0] b_d  [N];
  logic [N-1:0] s_d  [N];
  logic [N-1:0] c_d  [N];
  logic [N-1:0] lo_d [N];
  logic         v_q  [N];
  logic [N-1:0] a_q  [N];
  logic [N-1:0] b_q  [N];
  logic [N-1:0] s_q  [N];
  logic [N-1:0] c_q  [N];
  logic [N-1:0] lo_q [N];

  // Row 0: first partial-product row becomes the initial running sum.
  assign v_d[0]  = in_valid;
  assign a_d[0]  = a_in;
  assign b_d[0]  = b_in;
  assign s_d[0]  = a_in & {N{b_in[0]}};
  assign c_d[0]  = '0;
  assign lo_d[0] = '0;

  // Rows 1..N-1: add partial product j; the sum bit 0 of the row above is final.
  for (genvar j = 1; j < N; j++) begin : g_row
    logic [N-1:0] pp;
    assign pp = a_q[j-1] & {N{b_q[j-1][j]}};

    csa_fa_row #(.N(N)) u_fa_row (
      .pp    (pp),
      .s_in  ({1'b0, s_q[j-1][N-1:1]}),
      .c_in  (c_q[j-1]),
      .s_out (s_d[j]),
      .c_out (c_d[j])
    );

    assign v_d[j]  = v_q[j-1];
    assign a_d[j]  = a_q[j-1];
    assign b_d[j]  = b_q[j-1];
    assign lo_d[j] = lo_q[j-1] | (N'(s_q[j-1][0]) << (j - 1));
  end

  // Boundary after each row, present only where the mask bit is set.
  for (genvar j = 0; j < N; j++) begin : g_stage
    logic [RW-1:0] q_w;

    csa_stage_reg #(.W(RW), .REGISTER(STAGE_MASK[j])) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({v_d[j], a_d[j], b_d[j], s_d[j], c_d[j], lo_d[j]}),
      .q     (q_w)
    );

    assign {v_q[j], a_q[j], b_q[j], s_q[j], c_q[j], lo_q[j]} = q_w;
  end

  // Final carry-propagate adder merges the remaining sum and carry vectors.
  logic [N-1:0]  hi;
  logic [N-1:0]  lo_f;
  logic [PW:0]   out_w;

  csa_ripple_add #(.N(N)) u_final (
    .x   ({1'b0, s_q[N-1][N-1:1]}),
    .y   (c_q[N-1]),
    .sum (hi)
  );

  assign lo_f = lo_q[N-1] | (N'(s_q[N-1][0]) << (N - 1));

  csa_stage_reg #(.W(PW + 1), .REGISTER(STAGE_MASK[N])) u_out_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({v_q[N-1], hi, lo_f}),
    .q     (out_w)
  );

  assign {out_valid, product} = out_w;
endmodule

// File: rtl/csa_array_mul_chk.sv
`timescale 1ns/1ps
// Property checker for csa_array_mul, attached by bind below.
module csa_array_mul_chk #(
  parameter int unsigned N          = 8,
  parameter logic [N:0]  STAGE_MASK = 9'b1_0010_0100
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   a_in,
  input logic [N-1:0]   b_in,
  input logic           in_valid,
  input logic [2*N-1:0] product,
  input logic           out_valid
);
  localparam int unsigned PW  = 2 * N;
  localparam int unsigned LAT = csa_mul_pkg::count_ones(64'(STAGE_MASK), N + 1);

  logic          vdel;
  logic [PW-1:0] pdel;

  if (LAT == 0) begin : g_comb
    assign vdel = in_valid;
    assign pdel = PW'(a_in) * PW'(b_in);
  end else begin : g_delay
    logic          v_sh [LAT];
    logic [PW-1:0] p_sh [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < LAT; k++) begin
          v_sh[k] <= 1'b0;
          p_sh[k] <= '0;
        end
      end else begin
        v_sh[0] <= in_valid;
        p_sh[0] <= PW'(a_in) * PW'(b_in);
        for (int k = 1; k < LAT; k++) begin
          v_sh[k] <= v_sh[k-1];
          p_sh[k] <= p_sh[k-1];
        end
      end
    end

    assign vdel = v_sh[LAT-1];
    assign pdel = p_sh[LAT-1];

    // R4: pipelined outputs stay quiet while reset is held
    p_reset_quiet_r4: assert property (@(posedge clk) !rst_n |-> !out_valid);
  end

  // R1: every delivered product matches the delayed arithmetic product
  p_product_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product == pdel);

  // R3: each accepted pair leaves the block, none dropped
  p_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vdel |-> out_valid);

  // R5: no output without a matching accepted input
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> vdel);
endmodule

bind csa_array_mul csa_array_mul_chk #(.N(N), .STAGE_MASK(STAGE_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_in      (a_in),
  .b_in      (b_in),
  .in_valid  (in_valid),
  .product   (product),
  .out_valid (out_valid)
);

// File: tb/csa_array_mul_test.sv
`timescale 1ns/1ps
module csa_array_mul_test;
  localparam int unsigned N    = 4;
  localparam int unsigned PW   = 8;
  localparam int          LAT  = 3;     // set bits of 5'b10101
  localparam int          HIST = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  a_in = '0;
  logic [N-1:0]  b_in = '0;
  logic          in_valid = 1'b0;
  logic [PW-1:0] prod_p, prod_f;
  logic          ov_p, ov_f;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    run = 1'b0;
  string tag = "R2";

  logic          hv [HIST];
  logic [PW-1:0] hp [HIST];
  logic          hz [HIST];

  csa_array_mul #(.N(N), .STAGE_MASK(5'b10101)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .in_valid(in_valid),
    .product(prod_p), .out_valid(ov_p)
  );

  csa_array_mul #(.N(N), .STAGE_MASK(5'b00000)) uut_flat (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .in_valid(in_valid),
    .product(prod_f), .out_valid(ov_f)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive(input bit v, input int a, input int b);
    @(posedge clk);
    #1;
    in_valid = v;
    a_in     = a[N-1:0];
    b_in     = b[N-1:0];
    hv[cyc]  = v;
    hp[cyc]  = PW'(a * b);
    hz[cyc]  = (a == 0) || (b == 0) || (a == 15 && b == 15);
  endtask

  // Output monitor, sampled mid-cycle.
  always @(negedge clk) begin : mon
    int j;
    if (run && rst_n) begin
      j = cyc - LAT;
      if (j >= 0 && hv[j]) begin
        chk(ov_p == 1'b1, tag, longint'(ov_p), 1);
        chk(prod_p == hp[j], hz[j] ? "R7" : "R1", longint'(prod_p), longint'(hp[j]));
      end else begin
        chk(ov_p == 1'b0, "R5", longint'(ov_p), 0);
      end
      j = cyc;
      chk(ov_f == hv[j], "R6", longint'(ov_f), longint'(hv[j]));
      if (hv[j]) chk(prod_f == hp[j], "R6", longint'(prod_f), longint'(hp[j]));
    end
  end

  initial begin
    for (int i = 0; i < HIST; i++) begin
      hv[i] = 1'b0;
      hp[i] = '0;
      hz[i] = 1'b0;
    end
    // R4: state during reset
    repeat (2) @(negedge clk);
    chk(ov_p == 1'b0, "R4", longint'(ov_p), 0);
    chk(prod_p == '0, "R4", longint'(prod_p), 0);
    chk(ov_f == 1'b0, "R4", longint'(ov_f), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    run   = 1'b1;

    // R2: isolated pulse, then idle cycles carrying live operands (R5)
    tag = "R2";
    drive(1'b1, 13, 11);
    for (int i = 0; i < 6; i++) drive(1'b0, 7 + i, 9);

    // R3: every operand pair, back to back (R7 corners included)
    tag = "R3";
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) drive(1'b1, a, b);
    end

    // R2: gapped traffic
    tag = "R2";
    for (int i = 0; i < 48; i++) drive((i % 3) != 0, (i * 7) % 16, (i * 5 + 3) % 16);

    for (int i = 0; i < LAT + 3; i++) drive(1'b0, 5, 5);
    run = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule